// File: doc/BRIEF.md
# Push-Button Reset Request Debouncer

This block cleans up an active-low manual reset input that may come from a bouncing mechanical switch or from a logic signal, and turns it into a level-sensitive reset request for a downstream reset stretcher. The raw input is asynchronous to the block clock. A two-flop synchronizer brings it into the clock domain. A small state machine then qualifies the synchronized level against a free-running 1 ms tick strobe that is supplied from outside.

Four states make up the machine. IDLE means the input is high and no request is raised. A low sample moves IDLE to PRESS_QUAL, where low ticks are counted. Any high sample in PRESS_QUAL goes back to IDLE, and the tick that completes the confirm count goes to ACTIVE. ACTIVE raises the request. A high sample moves ACTIVE to RELEASE_QUAL, where the request stays raised while consecutive high ticks are counted. A low sample in RELEASE_QUAL goes back to ACTIVE, and the tick that completes the release count goes to IDLE.

The confirm count sets the acceptance threshold. It must be at least 2 ticks, so that a press shorter than one tick can never qualify. It must be at most 19 ticks, so that a press of 20 ms is always accepted. The post-release hold time of the reset is the stretcher's job.

Top module: `pb_debounce_top`

## Requirements
- R1: While `rst_n` is low, and after reset until a press qualifies, `rst_req` is 0.
- R2: A low level on `pb_n_raw` lasting less than one tick period never raises `rst_req`.
- R3: Any high sample during qualification discards the low ticks counted so far. Low stretches of up to 3 ticks each, separated by brief high gaps, therefore never raise `rst_req` at the default confirm count.
- R4: `rst_req` rises on the tick that completes CONFIRM_TICKS counted low ticks (default 4). A low level held for CONFIRM_TICKS+1 tick periods plus 2 clocks always raises it.
- R5: Once raised, `rst_req` stays 1 while the input is low. It falls on the tick that completes RELEASE_TICKS consecutive high ticks (default 2).
- R6: A low sample during release qualification keeps `rst_req` at 1, returns the machine to ACTIVE and discards the high ticks counted so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1ms | input | 1 | One-clock strobe, once per millisecond |
| pb_n_raw | input | 1 | Asynchronous active-low push-button input |
| rst_req | output | 1 | Level reset request, active high |

## Verification
A press counter that fails to clear shows at the port as a request raised after a series of short, separated glitches. This becomes visible within a few tick periods of the glitch train. A miscounted confirm or release count moves the rising or falling edge of `rst_req` by whole ticks, so checks placed one tick period inside either side of the nominal edge catch it. A release state that ignores a low sample drops the request within two ticks of a release bounce, while the input is still held low.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_PRESS_QUAL = 2'd1,
        ST_ACTIVE     = 2'd2,
        ST_REL_QUAL   = 2'd3
    } pbd_state_e;
endpackage

// File: rtl/pbd_sync2.sv
module pbd_sync2 #(
    parameter logic RESET_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_async,
    output logic dout
);
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= RESET_LEVEL;
            stable_q <= RESET_LEVEL;
        end else begin
            meta_q   <= din_async;
            stable_q <= meta_q;
        end
    end

    assign dout = stable_q;
endmodule

// File: rtl/pbd_fsm.sv
module pbd_fsm
    import pbd_pkg::*;
#(
    parameter int CONFIRM_TICKS = 4,
    parameter int RELEASE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lvl_hi,
    output logic req
);
    localparam int PCW = $clog2(CONFIRM_TICKS + 1);
    localparam int RCW = $clog2(RELEASE_TICKS + 1);
    localparam logic [PCW-1:0] PRESS_LAST = PCW'(CONFIRM_TICKS - 1);
    localparam logic [RCW-1:0] REL_LAST   = RCW'(RELEASE_TICKS - 1);

    generate
        if (CONFIRM_TICKS < 2 || CONFIRM_TICKS > 19) begin : g_bad_confirm
            $error("CONFIRM_TICKS must lie within 2..19");
        end
        if (RELEASE_TICKS < 2) begin : g_bad_release
            $error("RELEASE_TICKS must be at least 2");
        end
    endgenerate

    pbd_state_e       state_q, state_d;
    logic [PCW-1:0]   press_cnt_q, press_cnt_d;
    logic [RCW-1:0]   rel_cnt_q, rel_cnt_d;

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            press_cnt_q <= '0;
            rel_cnt_q   <= '0;
        end else begin
            state_q     <= state_d;
            press_cnt_q <= press_cnt_d;
            rel_cnt_q   <= rel_cnt_d;
        end
    end

    // Next-state process
    always_comb begin
        state_d     = state_q;
        press_cnt_d = press_cnt_q;
        rel_cnt_d   = rel_cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                rel_cnt_d = '0;
                if (!lvl_hi) begin
                    state_d     = ST_PRESS_QUAL;
                    press_cnt_d = tick ? PCW'(1) : '0;
                end else begin
                    press_cnt_d = '0;
                end
            end
            ST_PRESS_QUAL: begin
                if (lvl_hi) begin
                    state_d     = ST_IDLE;
                    press_cnt_d = '0;
                end else if (tick) begin
                    if (press_cnt_q == PRESS_LAST) begin
                        state_d     = ST_ACTIVE;
                        press_cnt_d = '0;
                    end else begin
                        press_cnt_d = press_cnt_q + PCW'(1);
                    end
                end
            end
            ST_ACTIVE: begin
                press_cnt_d = '0;
                if (lvl_hi) begin
                    state_d   = ST_REL_QUAL;
                    rel_cnt_d = tick ? RCW'(1) : '0;
                end else begin
                    rel_cnt_d = '0;
                end
            end
            ST_REL_QUAL: begin
                if (!lvl_hi) begin
                    state_d   = ST_ACTIVE;
                    rel_cnt_d = '0;
                end else if (tick) begin
                    if (rel_cnt_q == REL_LAST) begin
                        state_d   = ST_IDLE;
                        rel_cnt_d = '0;
                    end else begin
                        rel_cnt_d = rel_cnt_q + RCW'(1);
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        unique case (state_q)
            ST_ACTIVE, ST_REL_QUAL: req = 1'b1;
            default:                req = 1'b0;
        endcase
    end

    // R1
    req_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(state_q) == ST_PRESS_QUAL);

    // R3
    high_clears_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRESS_QUAL && lvl_hi) |=> (state_q == ST_IDLE && !req));

    // R4
    confirm_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> ($past(press_cnt_q) == PRESS_LAST && $past(tick)));

    // R5
    release_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req) |-> ($past(rel_cnt_q) == REL_LAST && $past(tick) && $past(lvl_hi)));

    // R6
    release_bounce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REL_QUAL && !lvl_hi) |=> (state_q == ST_ACTIVE && req));
endmodule

// File: rtl/pb_debounce_top.sv
module pb_debounce_top #(
    parameter int CONFIRM_TICKS = 4,
    parameter int RELEASE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_1ms,
    input  logic pb_n_raw,
    output logic rst_req
);
    logic pb_hi_sync;

    pbd_sync2 #(.RESET_LEVEL(1'b1)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .din_async (pb_n_raw),
        .dout      (pb_hi_sync)
    );

    pbd_fsm #(
        .CONFIRM_TICKS (CONFIRM_TICKS),
        .RELEASE_TICKS (RELEASE_TICKS)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1ms),
        .lvl_hi (pb_hi_sync),
        .req    (rst_req)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !rst_req);
endmodule

// File: tb/test_pb_debounce_top.sv
module test_pb_debounce_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 10;

    typedef struct {
        string tag;
        logic  exp;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_1ms = 1'b0;
    logic pb_n_raw = 1'b1;
    logic rst_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    exp_item_t sb_q[$];

    pb_debounce_top i_pb_debounce_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_1ms (tick_1ms),
        .pb_n_raw (pb_n_raw),
        .rst_req  (rst_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Tick strobe: one clock high every TICK_DIV clocks, changed at negedge
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
            tick_1ms = (cnt == TICK_DIV - 1);
        end
    end

    // Driver side: push expectation at a negedge
    task automatic expect_req(input string tag, input logic exp);
        exp_item_t it;
        it.tag = tag;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic hold(input logic lvl, input int clocks);
        pb_n_raw = lvl;
        repeat (clocks) @(negedge clk);
    endtask

    // Monitor: pop and compare just after each negedge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (rst_req !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: rst_req=%b expected=%b", it.tag, rst_req, it.exp);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        pb_n_raw = 1'b0;
        repeat (3) @(negedge clk);
        expect_req("R1 during reset", 1'b0);
        pb_n_raw = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        hold(1'b1, 30);
        expect_req("R1 after reset", 1'b0);

        // R2: short glitches under one tick period
        for (int i = 0; i < 6; i++) begin
            hold(1'b0, 5 + i);
            hold(1'b1, 14);
            expect_req("R2 short glitch", 1'b0);
        end

        // R3: low stretches of up to 3 ticks split by brief high gaps
        for (int i = 0; i < 5; i++) begin
            hold(1'b0, 25);
            expect_req("R3 segmented low", 1'b0);
            hold(1'b1, 3);
        end
        hold(1'b1, 20);
        expect_req("R3 after segments", 1'b0);

        // R4: sustained press, edge bounded on both sides
        hold(1'b0, 25);
        expect_req("R4 before confirm", 1'b0);
        hold(1'b0, 32);
        expect_req("R4 confirmed", 1'b1);
        hold(1'b0, 150);
        expect_req("R5 held low", 1'b1);

        // R5: release timing
        hold(1'b1, 5);
        expect_req("R5 early release", 1'b1);
        hold(1'b1, 32);
        expect_req("R5 released", 1'b0);

        // R6: bounce during release
        hold(1'b0, 70);
        expect_req("R6 re-pressed", 1'b1);
        for (int i = 0; i < 4; i++) begin
            hold(1'b1, 8);
            expect_req("R6 release bounce", 1'b1);
            hold(1'b0, 3);
            expect_req("R6 back low", 1'b1);
        end
        hold(1'b0, 40);
        expect_req("R6 still active", 1'b1);
        hold(1'b1, 40);
        expect_req("R5 final release", 1'b0);

        // R1: reset in the middle of an active request
        hold(1'b0, 70);
        expect_req("R4 second press", 1'b1);
        rst_n = 1'b0;
        hold(1'b0, 2);
        expect_req("R1 reset clears", 1'b0);
        pb_n_raw = 1'b1;
        rst_n = 1'b1;
        hold(1'b1, 10);
        expect_req("R1 idle after reset", 1'b0);

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule